// File: doc/BRIEF.md
# Stipple and Blit Pixel Engine

This block is a memory-mapped drawing helper that sits beside an 8-bit-per-pixel frame buffer. Software sends it commands through a 32-bit register bus with two windows. In the stipple window, a command paints the latched colour into the pixels picked out by a 32-bit mask. In the blit window, a command either fills a run of 1 to 32 pixels with the latched colour or copies a run of pixels from a source address. The engine reaches the pixel store through one single-port memory interface. That interface has a read latency of one cycle.

Every command takes two bus writes. A write whose address has bit 2 clear loads the colour register. A write whose address has bit 2 set starts the operation. The destination pixel address is carried in the upper bits of the bus address of that starting write, and its data word holds the mask or the blit descriptor. The bus uses a valid/ready handshake. A transfer completes on a rising edge where `bus_valid` and `bus_ready` are both high, and the master must hold its address, data and control stable until then. Only starting writes see back-pressure, and they are held off while an operation runs. Colour writes and reads are always accepted at once. When an operation ends, the block gives a one-cycle completion pulse that carries the region it touched, for dirty-region tracking.

Top module: `pix_stipple_blit`

## Requirements
- R1: A write with bus address bit 2 clear, in either window, stores the low 8 bits of the data as the colour. The colour is captured when an operation starts. A colour write made while the engine is busy is accepted without waiting and affects only later operations.
- R2: A write with bus address bit 2 set starts an operation. The destination pixel address is bus address bits 22:3. `bus_win` = 0 selects the stipple window and `bus_win` = 1 selects the blit window.
- R3: For a stipple, data bit 31-k controls pixel destination+k, for k from 0 to 31. A set bit writes the colour there. A clear bit leaves that pixel untouched, so a zero mask changes nothing.
- R4: For a blit, the run length is data bits 28:24 plus one, giving 1 to 32 pixels. Data bits 31:29 have no effect.
- R5: A blit whose data bits 23:0 are all ones fills the run with the colour.
- R6: Any other blit copies the run. The source pixel address is data bits 19:0. Pixels are moved one at a time in ascending order, each read followed by its write, so an overlapping forward copy repeats the first source pixel along the run.
- R7: Reads from either window complete without waiting and return 0.
- R8: A starting write that arrives while `busy` is high is held with `bus_ready` low until the running operation finishes. Operations never overlap.
- R9: In the cycle after an operation's last pixel, `done` is high for exactly one cycle, `busy` is low, `done_addr` holds the destination start, and `done_len` holds 32 for a stipple or the run length for a blit.
- R10: After reset, `busy` and `done` are low, no memory request is made, and the colour is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus transfer request |
| bus_ready | output | 1 | Bus transfer accepted on this edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | Window: 0 stipple, 1 blit |
| bus_addr | input | 23 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (always 0) |
| busy | output | 1 | Operation in progress |
| fb_req | output | 1 | Pixel memory request |
| fb_we | output | 1 | Pixel memory write enable |
| fb_addr | output | 20 | Pixel memory address |
| fb_wdata | output | 8 | Pixel write data |
| fb_rdata | input | 8 | Pixel read data, valid the cycle after a read request |
| done | output | 1 | One-cycle completion pulse |
| done_addr | output | 20 | Destination start of the finished operation |
| done_len | output | 6 | Pixel count of the finished operation |

## Verification
The assertions check the following on every cycle:
- no new operation starts while one is running;
- `done` never lasts longer than one cycle, and `busy` only falls together with it;
- the memory port stays quiet when the engine is idle;
- a stipple never issues a read;
- the reported length always lies between 1 and 32.

The bench scenarios cover what the assertions cannot see:
- the pixel contents after each command, compared with a reference memory, including the stipple bit order, the fill sentinel, overlapping forward copies and the two length extremes;
- the timing of the colour capture when the colour is rewritten during a run.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
  typedef enum logic [1:0] {
    OP_STIP = 2'd0,
    OP_FILL = 2'd1,
    OP_COPY = 2'd2
  } op_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_RD   = 2'd2,
    S_WR   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pxe_cmd_decode.sv
module pxe_cmd_decode
  import pxe_pkg::*;
#(
  parameter int PIX_AW  = 20,
  parameter int BUS_AW  = PIX_AW + 3,
  parameter int DATA_W  = 32,
  parameter int SRC_W   = 24,
  parameter int MAX_RUN = 32,
  parameter int LEN_W   = $clog2(MAX_RUN),
  parameter int CNT_W   = LEN_W + 1
) (
  input  logic              win,
  input  logic [BUS_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              is_trigger,
  output op_kind_e          kind,
  output logic [PIX_AW-1:0] dst,
  output logic [PIX_AW-1:0] src,
  output logic [MAX_RUN-1:0] mask,
  output logic [CNT_W-1:0]  len
);
  localparam logic [SRC_W-1:0] FILL_CODE = {SRC_W{1'b1}};

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:SRC_W+LEN_W], wdata[SRC_W-1:PIX_AW]};

  assign is_trigger = addr[2];
  assign dst        = addr[BUS_AW-1:3];
  assign src        = wdata[PIX_AW-1:0];
  assign mask       = wdata[MAX_RUN-1:0];

  always_comb begin
    if (win) begin
      len  = {1'b0, wdata[SRC_W +: LEN_W]} + CNT_W'(1);
      kind = (wdata[SRC_W-1:0] == FILL_CODE) ? OP_FILL : OP_COPY;
    end else begin
      len  = CNT_W'(MAX_RUN);
      kind = OP_STIP;
    end
  end
endmodule

// File: rtl/pxe_colour_reg.sv
module pxe_colour_reg #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] din,
  output logic [PIX_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/pxe_sequencer.sv
module pxe_sequencer
  import pxe_pkg::*;
#(
  parameter int PIX_AW  = 20,
  parameter int PIX_W   = 8,
  parameter int MAX_RUN = 32,
  parameter int CNT_W   = $clog2(MAX_RUN) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  op_kind_e           start_kind,
  input  logic [PIX_AW-1:0]  start_dst,
  input  logic [PIX_AW-1:0]  start_src,
  input  logic [MAX_RUN-1:0] start_mask,
  input  logic [CNT_W-1:0]   start_len,
  input  logic [PIX_W-1:0]   start_colour,
  output logic               busy,
  output logic               fb_req,
  output logic               fb_we,
  output logic [PIX_AW-1:0]  fb_addr,
  output logic [PIX_W-1:0]   fb_wdata,
  input  logic [PIX_W-1:0]   fb_rdata,
  output logic               done,
  output logic [PIX_AW-1:0]  done_addr,
  output logic [CNT_W-1:0]   done_len
);
  seq_state_e          state;
  op_kind_e            kind;
  logic [PIX_AW-1:0]   dst, src;
  logic [MAX_RUN-1:0]  mask;
  logic [CNT_W-1:0]    len, idx;
  logic [PIX_W-1:0]    colour;
  logic                last;
  logic [PIX_AW-1:0]   dst_cur, src_cur;

  assign busy    = (state != S_IDLE);
  assign last    = (idx == len - CNT_W'(1));
  assign dst_cur = dst + PIX_AW'(idx);
  assign src_cur = src + PIX_AW'(idx);

  always_comb begin
    fb_req   = 1'b0;
    fb_we    = 1'b0;
    fb_addr  = dst_cur;
    fb_wdata = colour;
    unique case (state)
      S_RUN: begin
        fb_req = (kind == OP_FILL) || mask[MAX_RUN-1];
        fb_we  = 1'b1;
      end
      S_RD: begin
        fb_req  = 1'b1;
        fb_addr = src_cur;
      end
      S_WR: begin
        fb_req   = 1'b1;
        fb_we    = 1'b1;
        fb_wdata = fb_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      kind      <= OP_STIP;
      dst       <= '0;
      src       <= '0;
      mask      <= '0;
      len       <= '0;
      idx       <= '0;
      colour    <= '0;
      done      <= 1'b0;
      done_addr <= '0;
      done_len  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          kind   <= start_kind;
          dst    <= start_dst;
          src    <= start_src;
          mask   <= start_mask;
          len    <= start_len;
          colour <= start_colour;
          idx    <= '0;
          state  <= (start_kind == OP_COPY) ? S_RD : S_RUN;
        end
        S_RUN: begin
          if (last) begin
            state     <= S_IDLE;
            done      <= 1'b1;
            done_addr <= dst;
            done_len  <= len;
          end else begin
            idx  <= idx + CNT_W'(1);
            mask <= mask << 1;
          end
        end
        S_RD: state <= S_WR;
        S_WR: begin
          if (last) begin
            state     <= S_IDLE;
            done      <= 1'b1;
            done_addr <= dst;
            done_len  <= len;
          end else begin
            idx   <= idx + CNT_W'(1);
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_FALLS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fb_req); // R10
  AST_STIP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == OP_STIP) |-> !(fb_req && !fb_we)); // R3
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_len >= CNT_W'(1) && done_len <= CNT_W'(MAX_RUN))); // R4
endmodule

// File: rtl/pix_stipple_blit.sv
module pix_stipple_blit
  import pxe_pkg::*;
#(
  parameter int PIX_AW  = 20,
  parameter int PIX_W   = 8,
  parameter int DATA_W  = 32,
  parameter int SRC_W   = 24,
  parameter int MAX_RUN = 32,
  localparam int BUS_AW = PIX_AW + 3,
  localparam int CNT_W  = $clog2(MAX_RUN) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic              bus_win,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              fb_req,
  output logic              fb_we,
  output logic [PIX_AW-1:0] fb_addr,
  output logic [PIX_W-1:0]  fb_wdata,
  input  logic [PIX_W-1:0]  fb_rdata,
  output logic              done,
  output logic [PIX_AW-1:0] done_addr,
  output logic [CNT_W-1:0]  done_len
);
  logic               is_trig, accept, colour_load, start;
  op_kind_e           dec_kind;
  logic [PIX_AW-1:0]  dec_dst, dec_src;
  logic [MAX_RUN-1:0] dec_mask;
  logic [CNT_W-1:0]   dec_len;
  logic [PIX_W-1:0]   colour;

  pxe_cmd_decode #(
    .PIX_AW(PIX_AW), .BUS_AW(BUS_AW), .DATA_W(DATA_W),
    .SRC_W(SRC_W), .MAX_RUN(MAX_RUN), .CNT_W(CNT_W)
  ) u_decode (
    .win(bus_win), .addr(bus_addr), .wdata(bus_wdata),
    .is_trigger(is_trig), .kind(dec_kind), .dst(dec_dst),
    .src(dec_src), .mask(dec_mask), .len(dec_len)
  );

  assign bus_ready   = !(bus_write && is_trig && busy);
  assign accept      = bus_valid && bus_ready && bus_write;
  assign colour_load = accept && !is_trig;
  assign start       = accept && is_trig;
  assign bus_rdata   = '0;

  pxe_colour_reg #(.PIX_W(PIX_W)) u_colour (
    .clk(clk), .rst_n(rst_n), .load(colour_load),
    .din(bus_wdata[PIX_W-1:0]), .q(colour)
  );

  pxe_sequencer #(
    .PIX_AW(PIX_AW), .PIX_W(PIX_W), .MAX_RUN(MAX_RUN), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_kind(dec_kind), .start_dst(dec_dst), .start_src(dec_src),
    .start_mask(dec_mask), .start_len(dec_len), .start_colour(colour),
    .busy(busy), .fb_req(fb_req), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_wdata(fb_wdata), .fb_rdata(fb_rdata),
    .done(done), .done_addr(done_addr), .done_len(done_len)
  );

  AST_COLOUR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !bus_addr[2]) |-> bus_ready); // R1
endmodule

// File: tb/tb_pix_stipple_blit.sv
module tb_pix_stipple_blit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bus_valid, bus_ready, bus_write, bus_win;
  logic [22:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        busy, fb_req, fb_we, done;
  logic [19:0] fb_addr, done_addr;
  logic [7:0]  fb_wdata, fb_rdata;
  logic [5:0]  done_len;

  pix_stipple_blit dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_win(bus_win), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .fb_req(fb_req), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_rdata(fb_rdata), .done(done), .done_addr(done_addr), .done_len(done_len)
  );

  logic [7:0] fb_mem  [4096];
  logic [7:0] ref_mem [4096];
  logic [7:0] ref_colour;
  int checks = 0;
  int failures = 0;

  always @(posedge clk) begin
    if (fb_req) begin
      if (fb_we) fb_mem[fb_addr[11:0]] <= fb_wdata;
      else       fb_rdata <= fb_mem[fb_addr[11:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_op(input bit win, input bit wr, input logic [22:0] addr,
                        input logic [31:0] data, output logic [31:0] rd,
                        output int waits);
    waits = 0;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_win = win;
    bus_addr = addr; bus_wdata = data;
    #1;
    while (!bus_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
  endtask

  task automatic set_colour(input bit win, input logic [31:0] c, output int waits);
    logic [31:0] rd;
    bus_op(win, 1'b1, {20'($urandom % 4096), 3'b000}, c, rd, waits);
    ref_colour = c[7:0];
  endtask

  task automatic model_stip(input int dst, input logic [31:0] m);
    for (int k = 0; k < 32; k++)
      if (m[31-k]) ref_mem[(dst + k) % 4096] = ref_colour;
  endtask

  task automatic model_blit(input int dst, input logic [31:0] d);
    int n = int'(d[28:24]) + 1;
    for (int k = 0; k < n; k++) begin
      if (d[23:0] == 24'hFFFFFF) ref_mem[(dst + k) % 4096] = ref_colour;
      else ref_mem[(dst + k) % 4096] = ref_mem[(int'(d[19:0]) + k) % 4096];
    end
  endtask

  task automatic trigger(input bit win, input int dst, input logic [31:0] d,
                         output int waits);
    logic [31:0] rd;
    bus_op(win, 1'b1, {20'(dst), 3'b100}, d, rd, waits);
    if (win) model_blit(dst, d); else model_stip(dst, d);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    @(negedge clk);
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, req, "done pulse seen", done, 1);
  endtask

  task automatic check_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < 4096; i++)
      if (fb_mem[i] !== ref_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, req, "pixels", 0, 0);
    else chk(1'b0, req, $sformatf("pixel %0d", first), fb_mem[first], ref_mem[first]);
  endtask

  task automatic run_op(input bit win, input int dst, input logic [31:0] d,
                        input string req);
    int w;
    int exp_len = win ? int'(d[28:24]) + 1 : 32;
    trigger(win, dst, d, w);
    wait_done(req);
    chk(done_addr == 20'(dst), "R9", "done_addr", done_addr, dst);
    chk(done_len == 6'(exp_len), req, "done_len", done_len, exp_len);
    chk(busy == 1'b0, "R9", "busy at done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", done, 0);
    check_mem(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w;
    logic [31:0] rd, d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin
      fb_mem[i] = 8'($urandom);
      ref_mem[i] = fb_mem[i];
    end
    ref_colour = 8'h00;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_win = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10", "busy/done after reset", {busy, done}, 0);
    chk(fb_req == 1'b0, "R10", "fb_req after reset", fb_req, 0);
    chk(bus_ready == 1'b1, "R10", "bus_ready after reset", bus_ready, 1);

    // R10: reset colour is 0; R3: bit 31 -> dst+0, bit 0 -> dst+31
    run_op(1'b0, 100, 32'h8000_0001, "R3");
    chk(fb_mem[100] == 8'h00 && fb_mem[131] == 8'h00, "R10", "reset colour", fb_mem[100], 0);
    set_colour(1'b1, 32'hABCD_125A, w);
    run_op(1'b0, 300, 32'h0000_0000, "R3");       // zero mask: nothing changes
    run_op(1'b0, 400, 32'hF0F0_A5C3, "R3");
    // R4/R5: fill length extremes, upper bits ignored
    set_colour(1'b0, 32'h0000_0077, w);
    run_op(1'b1, 600, 32'hE0FF_FFFF, "R5");        // field 0 -> 1 pixel
    run_op(1'b1, 700, 32'h1FFF_FFFF, "R4");        // field 31 -> 32 pixels
    // R6: overlapping forward copy replicates first pixel
    run_op(1'b1, 901, 32'h0700_0384, "R6");        // src 900, 8 pixels
    run_op(1'b1, 1000, 32'h3F00_0500, "R6");       // disjoint copy, 32 pixels
    // R2: destination from bus address bits 22:3
    run_op(1'b1, 4000, 32'h0400_0010, "R2");

    // R7: reads return 0 without wait, also while busy
    bus_op(1'b0, 1'b0, 23'h000123, 32'h0, rd, w);
    chk(rd == 32'h0 && w == 0, "R7", "stipple read", rd, 0);
    trigger(1'b1, 1200, 32'h1FFF_FFFF, w);
    bus_op(1'b1, 1'b0, 23'h000004, 32'h0, rd, w);
    chk(rd == 32'h0 && w == 0, "R7", "blit read while busy", rd, 0);
    // R1: colour written mid-run, no wait, used only later
    set_colour(1'b0, 32'h0000_0033, w);
    chk(w == 0, "R1", "colour write waits", w, 0);
    // R8: second trigger stalls until first finishes
    trigger(1'b0, 1300, 32'hFFFF_FFFF, w);
    chk(w > 0, "R8", "trigger stall cycles", w, 1);
    wait_done("R8");
    chk(done_addr == 20'd1300, "R8", "second op addr", done_addr, 1300);
    @(negedge clk);
    check_mem("R1");

    // random mix
    for (int n = 0; n < 80; n++) begin
      int kind = $urandom % 3;
      int dst = $urandom % 4000;
      if ($urandom % 2) set_colour(1'($urandom), $urandom, w);
      if (kind == 0) run_op(1'b0, dst, $urandom, "R3");
      else if (kind == 1) begin
        d = {3'($urandom), 5'($urandom), 24'hFFFFFF};
        run_op(1'b1, dst, d, "R5");
      end else begin
        d = {3'($urandom), 5'($urandom), 4'h0, 20'($urandom % 4000)};
        run_op(1'b1, dst, d, "R6");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule